// File: doc/BRIEF.md
# Serial Memory Command Front-End

This block is the slave side of a serial link to a byte-addressed nonvolatile store. A host frames each transaction with an active-low select. The block takes in a command byte, an optional 16-bit address and data bytes, and returns read data or status on a serial output line. SCK, SI, select and the pause input are asynchronous to the block. They are brought into a faster system clock through two-flop synchronisers. Input bits are captured on rising SCK and output bits are launched on falling SCK, so both idle polarities of the clock (mode 0 and mode 3) work without configuration.

Reads are served from a synchronous RAM port with one cycle of latency. The block fetches each byte ahead of the falling edge that launches its first bit. Programming, the enable latch and block protection belong to neighbouring blocks. The front-end only emits request pulses to them, and it honours their `grant_i` and `busy_i` levels.

Top module: `sermem_cmd_front`

## Requirements
- R1: A command byte has its upper four bits zero and bit 3 ignored. Bits [2:0] select the operation: 110 enable, 100 disable, 101 status read, 001 status write, 011 array read, 010 array write. The values 000 and 111, and any byte with a nonzero upper nibble, are invalid.
- R2: Command, address and data bits travel most significant bit first, and every transaction begins at a falling edge of `cs_n_i`.
- R3: After an invalid command, the block accepts no further input, emits no request and keeps `so_oe_o` low until the next falling edge of `cs_n_i`. The transaction that follows is decoded normally.
- R4: While `cs_n_i` is high, SCK and SI activity has no effect and `so_oe_o` is low. `so_oe_o` is also low after reset.
- R5: Pulling `hold_n_i` low while SCK is low pauses the transaction. During the pause `so_oe_o` is low, SCK edges and SI are ignored, and the bit position is kept. Raising `hold_n_i` while SCK is low resumes the transaction at the same bit.
- R6: An array read takes two address bytes and then streams bytes continuously. The address increments after each byte and wraps from the top address to 0. Address bits at and above `MEM_AW` are ignored.
- R7: While `busy_i` is high at the end of the command byte, every command except status read is ignored in the same way as an invalid one.
- R8: A status read streams `status_i`. The value is sampled again for every byte.
- R9: The enable and disable commands each produce a single-cycle `wren_o` or `wrdi_o` pulse.
- R10: An array write proceeds only if `grant_i` is high at the end of the command byte. Each whole data byte is presented on `pg_vld_o` with its address. The low `PAGE_AW` address bits increment and wrap inside the page, and the upper bits hold. `pg_commit_o` pulses when select rises on a byte boundary after at least one data byte, and does not pulse otherwise.
- R11: A status write proceeds only if `grant_i` is high at the end of the command byte. `sr_wr_o` pulses with the last whole byte when select rises on a byte boundary.
- R12: Mode 0 (SCK idle low) and mode 3 (SCK idle high) behave identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from host |
| cs_n_i | input | 1 | Active-low select framing a transaction |
| si_i | input | 1 | Serial data from host |
| hold_n_i | input | 1 | Active-low pause request |
| so_o | output | 1 | Serial data to host |
| so_oe_o | output | 1 | Output enable for `so_o`; low means high impedance |
| mem_rd_en_o | output | 1 | Array read strobe |
| mem_addr_o | output | MEM_AW | Array read address |
| mem_rd_data_i | input | 8 | Array read data, valid one cycle after the strobe |
| status_i | input | 8 | Status byte provided by the protection block |
| busy_i | input | 1 | Internal programming cycle in progress |
| grant_i | input | 1 | Permission for array or status writes |
| wren_o | output | 1 | Enable-command pulse |
| wrdi_o | output | 1 | Disable-command pulse |
| pg_vld_o | output | 1 | Data byte for the page engine is valid |
| pg_addr_o | output | MEM_AW | Address of that data byte |
| pg_data_o | output | 8 | Data byte |
| pg_commit_o | output | 1 | Start of programming |
| sr_wr_o | output | 1 | Status write request |
| sr_data_o | output | 8 | Status byte to be written |

## Verification
Assertions check three things on every cycle: the output stays disabled once select has been high for two cycles, the bit position stays frozen during a pause, and the ignore state does not leave while select is low. They also check that at most one request pulse fires in a cycle, and that no enable or disable pulse follows a command decoded while busy. Only the bench scenarios show whether the content is correct: bytes shifted out MSB first across the address wrap, the ignored high address bit, bytes surviving a pause with junk on SI, and page wrap and commit rules on the write path. The same holds for the status value reloaded per byte and for identical results in both clock modes.

// File: rtl/sfe_pkg.sv
`timescale 1ns/100ps
// Shared types for the serial memory command front-end.
// Assumes nothing beyond IEEE 1800-2017.
package sfe_pkg;
    // Transaction phase, one per stage of a framed command.
    typedef enum logic [2:0] {
        PH_IDLE,   // select high
        PH_OPC,    // shifting the command byte
        PH_ADDR,   // shifting two address bytes
        PH_RDOUT,  // streaming array bytes out
        PH_SROUT,  // streaming status bytes out
        PH_WRIN,   // collecting page data
        PH_SRIN,   // collecting status data
        PH_IGN     // ignoring everything until select rises
    } phase_t;

    // Low three bits of a valid command byte.
    localparam logic [2:0] OPC_WREN  = 3'b110;
    localparam logic [2:0] OPC_WRDI  = 3'b100;
    localparam logic [2:0] OPC_RDSR  = 3'b101;
    localparam logic [2:0] OPC_WRSR  = 3'b001;
    localparam logic [2:0] OPC_READ  = 3'b011;
    localparam logic [2:0] OPC_WRITE = 3'b010;
endpackage

// File: rtl/sfe_sync.sv
`timescale 1ns/100ps
// Two-flop synchroniser for a bundle of independent asynchronous inputs.
// Assumes each bit is a level signal; no multi-bit coherence is implied.
module sfe_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages towards the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sfe_link.sv
`timescale 1ns/100ps
// Link-level event detector: SCK edges, select edges and the pause state.
// Assumes inputs are already synchronised. Edges are suppressed while
// select is high or a pause is active.
module sfe_link (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cs_n_s,
    input  logic hold_n_s,
    output logic rise_o,
    output logic fall_o,
    output logic cs_fall_o,
    output logic cs_rise_o,
    output logic held_o
);
    logic sck_d;
    logic cs_d;

    // Previous-cycle copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    // Pause state changes only while SCK is low; cleared when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)       held_o <= 1'b0;
        else if (cs_n_s)  held_o <= 1'b0;
        else if (!sck_s)  held_o <= !hold_n_s;
    end

    // Qualified edge events.
    always_comb begin
        rise_o    = sck_s && !sck_d && !cs_n_s && !held_o;
        fall_o    = !sck_s && sck_d && !cs_n_s && !held_o;
        cs_fall_o = !cs_n_s && cs_d;
        cs_rise_o = cs_n_s && !cs_d;
    end
endmodule

// File: rtl/sfe_cmd.sv
`timescale 1ns/100ps
// Command decoder and input shifter. It collects the command byte, the
// address and data bytes, and issues requests to the neighbouring blocks.
// Assumes rise_i only fires while select is low and no pause is active.
module sfe_cmd
    import sfe_pkg::*;
#(
    parameter int MEM_AW  = 16,
    parameter int PAGE_AW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              cs_fall_i,
    input  logic              cs_rise_i,
    input  logic              si_i,
    input  logic              held_i,
    input  logic              busy_i,
    input  logic              grant_i,
    output phase_t            phase_o,
    output logic              rd_start_o,
    output logic              sr_start_o,
    output logic [MEM_AW-1:0] rd_addr_o,
    output logic              wren_o,
    output logic              wrdi_o,
    output logic              pg_vld_o,
    output logic [MEM_AW-1:0] pg_addr_o,
    output logic [7:0]        pg_data_o,
    output logic              pg_commit_o,
    output logic              sr_wr_o,
    output logic [7:0]        sr_data_o
);
    localparam logic [PAGE_AW-1:0] PG_ONE = {{(PAGE_AW-1){1'b0}}, 1'b1};

    phase_t            phase;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx;
    logic [7:0]        addr_hi;
    logic              addr_second;
    logic              is_wr;
    logic              got_byte;
    logic [MEM_AW-1:0] wr_ptr;
    logic [7:0]        byte_in;
    logic              byte_done;
    logic [15:0]       addr_full;
    logic              shifting;

    // Byte currently completing and the full address it would form.
    always_comb begin
        byte_in   = {rx, si_i};
        byte_done = rise_i && (bit_cnt == 3'd7);
        addr_full = {addr_hi, byte_in};
        shifting  = rise_i && (phase != PH_IDLE) && (phase != PH_IGN);
    end

    assign phase_o = phase;

    // Phase sequencing, shifting and request generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            bit_cnt     <= 3'd0;
            rx          <= 7'd0;
            addr_hi     <= 8'd0;
            addr_second <= 1'b0;
            is_wr       <= 1'b0;
            got_byte    <= 1'b0;
            wr_ptr      <= '0;
            rd_start_o  <= 1'b0;
            sr_start_o  <= 1'b0;
            rd_addr_o   <= '0;
            wren_o      <= 1'b0;
            wrdi_o      <= 1'b0;
            pg_vld_o    <= 1'b0;
            pg_addr_o   <= '0;
            pg_data_o   <= 8'd0;
            pg_commit_o <= 1'b0;
            sr_wr_o     <= 1'b0;
            sr_data_o   <= 8'd0;
        end else begin
            rd_start_o  <= 1'b0;
            sr_start_o  <= 1'b0;
            wren_o      <= 1'b0;
            wrdi_o      <= 1'b0;
            pg_vld_o    <= 1'b0;
            pg_commit_o <= 1'b0;
            sr_wr_o     <= 1'b0;
            if (cs_rise_i) begin
                pg_commit_o <= (phase == PH_WRIN) && got_byte && (bit_cnt == 3'd0);
                sr_wr_o     <= (phase == PH_SRIN) && got_byte && (bit_cnt == 3'd0);
                phase       <= PH_IDLE;
                bit_cnt     <= 3'd0;
            end else if (cs_fall_i) begin
                phase       <= PH_OPC;
                bit_cnt     <= 3'd0;
                addr_second <= 1'b0;
                got_byte    <= 1'b0;
            end else if (shifting) begin
                rx      <= byte_in[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (byte_done) begin
                    unique case (phase)
                        PH_OPC: begin
                            if (byte_in[7:4] != 4'd0) begin
                                phase <= PH_IGN;
                            end else if (busy_i && byte_in[2:0] != OPC_RDSR) begin
                                phase <= PH_IGN;
                            end else begin
                                unique case (byte_in[2:0])
                                    OPC_WREN: begin wren_o <= 1'b1; phase <= PH_IGN; end
                                    OPC_WRDI: begin wrdi_o <= 1'b1; phase <= PH_IGN; end
                                    OPC_RDSR: begin sr_start_o <= 1'b1; phase <= PH_SROUT; end
                                    OPC_WRSR: phase <= grant_i ? PH_SRIN : PH_IGN;
                                    OPC_READ: begin is_wr <= 1'b0; phase <= PH_ADDR; end
                                    OPC_WRITE: begin
                                        is_wr <= 1'b1;
                                        phase <= grant_i ? PH_ADDR : PH_IGN;
                                    end
                                    default: phase <= PH_IGN;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            if (!addr_second) begin
                                addr_hi     <= byte_in;
                                addr_second <= 1'b1;
                            end else if (is_wr) begin
                                wr_ptr <= addr_full[MEM_AW-1:0];
                                phase  <= PH_WRIN;
                            end else begin
                                rd_addr_o  <= addr_full[MEM_AW-1:0];
                                rd_start_o <= 1'b1;
                                phase      <= PH_RDOUT;
                            end
                        end
                        PH_WRIN: begin
                            pg_vld_o  <= 1'b1;
                            pg_addr_o <= wr_ptr;
                            pg_data_o <= byte_in;
                            wr_ptr    <= {wr_ptr[MEM_AW-1:PAGE_AW], wr_ptr[PAGE_AW-1:0] + PG_ONE};
                            got_byte  <= 1'b1;
                        end
                        PH_SRIN: begin
                            sr_data_o <= byte_in;
                            got_byte  <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R3: once ignoring, stay there until select rises.
    a_r3_ignore_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IGN && !cs_rise_i) |=> (phase == PH_IGN));

    // R5: the bit position is frozen while paused.
    a_r5_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (held_i && $past(held_i)) |-> $stable(bit_cnt));

    // R7: no enable or disable request follows a command decoded while busy.
    a_r7_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wren_o || wrdi_o) |-> !$past(busy_i));

    // R9: at most one request pulse per cycle.
    a_r9_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wren_o, wrdi_o, pg_vld_o, pg_commit_o, sr_wr_o}));
endmodule

// File: rtl/sfe_tx.sv
`timescale 1ns/100ps
// Output shifter. It fetches array or status bytes one byte ahead and
// launches bits MSB first on falling SCK. Assumes the RAM returns data
// one cycle after its strobe, and at least three system cycles between
// SCK edges.
module sfe_tx
    import sfe_pkg::*;
#(
    parameter int MEM_AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase_i,
    input  logic              fall_i,
    input  logic              held_i,
    input  logic              rd_start_i,
    input  logic              sr_start_i,
    input  logic [MEM_AW-1:0] rd_addr_i,
    input  logic [7:0]        mem_rd_data_i,
    input  logic [7:0]        status_i,
    output logic              mem_rd_en_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic              so_o,
    output logic              so_oe_o
);
    localparam logic [MEM_AW-1:0] A_ONE = {{(MEM_AW-1){1'b0}}, 1'b1};

    logic [MEM_AW-1:0] ptr;
    logic [7:0]        tx_byte;
    logic [2:0]        tx_idx;
    logic              load_mem;
    logic              load_sr;
    logic              so_q;
    logic              act_rd;
    logic              act_sr;
    logic              launch;
    logic              last_bit;

    // Launch control and the read strobe towards the RAM.
    always_comb begin
        act_rd      = (phase_i == PH_RDOUT);
        act_sr      = (phase_i == PH_SROUT);
        launch      = fall_i && (act_rd || act_sr);
        last_bit    = launch && (tx_idx == 3'd7);
        mem_rd_en_o = rd_start_i || (last_bit && act_rd);
        mem_addr_o  = rd_start_i ? rd_addr_i : ptr;
        so_oe_o     = (act_rd || act_sr) && !held_i;
        so_o        = so_q;
    end

    // Read pointer, byte prefetch and bit launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            tx_byte  <= 8'd0;
            tx_idx   <= 3'd0;
            load_mem <= 1'b0;
            load_sr  <= 1'b0;
            so_q     <= 1'b0;
        end else begin
            if (rd_start_i)              ptr <= rd_addr_i + A_ONE;
            else if (last_bit && act_rd) ptr <= ptr + A_ONE;
            load_mem <= mem_rd_en_o;
            load_sr  <= sr_start_i || (last_bit && act_sr);
            if (load_mem)     tx_byte <= mem_rd_data_i;
            else if (load_sr) tx_byte <= status_i;
            if (rd_start_i || sr_start_i) tx_idx <= 3'd0;
            else if (launch)              tx_idx <= tx_idx + 3'd1;
            if (launch) so_q <= tx_byte[3'd7 - tx_idx];
        end
    end
endmodule

// File: rtl/sermem_cmd_front.sv
`timescale 1ns/100ps
// Serial memory command front-end top. It synchronises the serial pins,
// detects link events, decodes commands and streams read data. Assumes
// clk runs at least eight times faster than SCK.
module sermem_cmd_front
    import sfe_pkg::*;
#(
    parameter int MEM_AW  = 16,
    parameter int PAGE_AW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              si_i,
    input  logic              hold_n_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              mem_rd_en_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    input  logic [7:0]        mem_rd_data_i,
    input  logic [7:0]        status_i,
    input  logic              busy_i,
    input  logic              grant_i,
    output logic              wren_o,
    output logic              wrdi_o,
    output logic              pg_vld_o,
    output logic [MEM_AW-1:0] pg_addr_o,
    output logic [7:0]        pg_data_o,
    output logic              pg_commit_o,
    output logic              sr_wr_o,
    output logic [7:0]        sr_data_o
);
    logic              sck_s, cs_n_s, si_s, hold_n_s;
    logic              rise, fall, cs_fall, cs_rise, held;
    phase_t            phase;
    logic              rd_start, sr_start;
    logic [MEM_AW-1:0] rd_addr;

    sfe_sync #(.W(4), .RST_VAL(4'b0101)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, cs_n_i, si_i, hold_n_i}),
        .q     ({sck_s, cs_n_s, si_s, hold_n_s})
    );

    sfe_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (sck_s),
        .cs_n_s    (cs_n_s),
        .hold_n_s  (hold_n_s),
        .rise_o    (rise),
        .fall_o    (fall),
        .cs_fall_o (cs_fall),
        .cs_rise_o (cs_rise),
        .held_o    (held)
    );

    sfe_cmd #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .cs_fall_i   (cs_fall),
        .cs_rise_i   (cs_rise),
        .si_i        (si_s),
        .held_i      (held),
        .busy_i      (busy_i),
        .grant_i     (grant_i),
        .phase_o     (phase),
        .rd_start_o  (rd_start),
        .sr_start_o  (sr_start),
        .rd_addr_o   (rd_addr),
        .wren_o      (wren_o),
        .wrdi_o      (wrdi_o),
        .pg_vld_o    (pg_vld_o),
        .pg_addr_o   (pg_addr_o),
        .pg_data_o   (pg_data_o),
        .pg_commit_o (pg_commit_o),
        .sr_wr_o     (sr_wr_o),
        .sr_data_o   (sr_data_o)
    );

    sfe_tx #(.MEM_AW(MEM_AW)) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase_i       (phase),
        .fall_i        (fall),
        .held_i        (held),
        .rd_start_i    (rd_start),
        .sr_start_i    (sr_start),
        .rd_addr_i     (rd_addr),
        .mem_rd_data_i (mem_rd_data_i),
        .status_i      (status_i),
        .mem_rd_en_o   (mem_rd_en_o),
        .mem_addr_o    (mem_addr_o),
        .so_o          (so_o),
        .so_oe_o       (so_oe_o)
    );

    // R4: the output is disabled once select has been high for two cycles.
    a_r4_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> !so_oe_o);
endmodule

// File: tb/sermem_cmd_front_bench.sv
`timescale 1ns/100ps
// Scoreboard bench: driver tasks queue expected requests, a monitor pops
// and compares them; read bytes are compared against a reference array.
module sermem_cmd_front_bench;
    localparam int AW = 15;
    localparam int H  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
    logic so_o, so_oe_o, mem_rd_en_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0] mem_rd_data;
    logic [7:0] status = 8'h00;
    logic busy = 1'b0, grant = 1'b0;
    logic wren_o, wrdi_o, pg_vld_o, pg_commit_o, sr_wr_o;
    logic [AW-1:0] pg_addr_o;
    logic [7:0] pg_data_o, sr_data_o;

    logic [7:0] ram [0:(1<<AW)-1];
    logic [31:0] exp_q[$];
    int n_chk = 0, n_fail = 0;
    bit oe_seen = 1'b0;

    always #2.5 clk = ~clk;

    sermem_cmd_front #(.MEM_AW(AW), .PAGE_AW(7)) u_sermem_cmd_front (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
        .hold_n_i(hold_n), .so_o(so_o), .so_oe_o(so_oe_o),
        .mem_rd_en_o(mem_rd_en_o), .mem_addr_o(mem_addr_o),
        .mem_rd_data_i(mem_rd_data), .status_i(status), .busy_i(busy),
        .grant_i(grant), .wren_o(wren_o), .wrdi_o(wrdi_o),
        .pg_vld_o(pg_vld_o), .pg_addr_o(pg_addr_o), .pg_data_o(pg_data_o),
        .pg_commit_o(pg_commit_o), .sr_wr_o(sr_wr_o), .sr_data_o(sr_data_o)
    );

    // Reference synchronous RAM with one cycle of read latency.
    always_ff @(posedge clk) if (mem_rd_en_o) mem_rd_data <= ram[mem_addr_o];

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic string rq_of(input logic [31:0] it);
        case (it[31:24])
            8'd1, 8'd2: return "R9 request";
            8'd3, 8'd4: return "R10 page";
            default:    return "R11 status write";
        endcase
    endfunction

    // Monitor: pop and compare requests, and track any output enable.
    always @(negedge clk) begin
        logic [31:0] got;
        logic [31:0] e;
        if (rst_n && (wren_o || wrdi_o || pg_vld_o || pg_commit_o || sr_wr_o)) begin
            if (wren_o)         got = {8'd1, 16'd0, 8'd0};
            else if (wrdi_o)    got = {8'd2, 16'd0, 8'd0};
            else if (pg_vld_o)  got = {8'd3, 1'b0, pg_addr_o, pg_data_o};
            else if (pg_commit_o) got = {8'd4, 16'd0, 8'd0};
            else                got = {8'd5, 16'd0, sr_data_o};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 R7 unexpected request", int'(got), 0);
            end else begin
                e = exp_q.pop_front();
                chk(got == e, rq_of(e), int'(got), int'(e));
            end
        end
        if (so_oe_o) oe_seen = 1'b1;
    end

    task automatic sb_drain(input string rq);
        #(4*H);
        chk(exp_q.size() == 0, rq, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic pause(input logic b);
        #H; hold_n = 1'b0; #H;
        chk(so_oe_o == 1'b0, "R5 output off in pause", so_oe_o, 0);
        repeat (3) begin
            sck = 1'b1; si = ~si; #H;
            sck = 1'b0; si = ~si; #H;
        end
        si = b; #H; hold_n = 1'b1; #H;
    endtask

    task automatic xbyte(input logic [7:0] tx, input int hold_at, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = tx[i];
            if (i == hold_at) pause(tx[i]);
            #H; rx[i] = so_o; sck = 1'b1; #H;
        end
    endtask

    task automatic begin_x(input bit m3);
        sck = m3; #H; cs_n = 1'b0; #H;
    endtask

    task automatic end_x(input bit m3);
        if (!m3) sck = 1'b0;
        #H; cs_n = 1'b1; #(2*H);
    endtask

    task automatic one_cmd(input logic [7:0] op, input bit m3);
        logic [7:0] rx;
        begin_x(m3); xbyte(op, -1, rx); end_x(m3);
    endtask

    task automatic do_read(input logic [7:0] op, input logic [15:0] a, input int n,
                           input bit m3, input int h_addr, input int h_data, input string rq);
        logic [7:0] rx;
        begin_x(m3);
        xbyte(op, -1, rx); xbyte(a[15:8], -1, rx); xbyte(a[7:0], h_addr, rx);
        for (int k = 0; k < n; k++) begin
            logic [7:0] ex;
            xbyte(8'hFF, (k == 0) ? h_data : -1, rx);
            ex = ram[AW'(a + 16'(k))];
            chk(rx == ex, rq, rx, ex);
        end
        end_x(m3);
    endtask

    task automatic do_rdsr(input int n, input logic [7:0] ex, input bit m3, input string rq);
        logic [7:0] rx;
        begin_x(m3); xbyte(8'h05, -1, rx);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, -1, rx);
            chk(rx == ex, rq, rx, ex);
        end
        end_x(m3);
    endtask

    initial begin
        #(500000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        for (int i = 0; i < (1 << AW); i++) ram[i] = 8'(i * 13 + (i >> 7));
        #1;
        #(10*H);
        chk(so_oe_o == 1'b0, "R4 reset output off", so_oe_o, 0);
        chk({wren_o, wrdi_o, pg_vld_o, pg_commit_o, sr_wr_o} == 5'd0, "R4 reset no request",
            {wren_o, wrdi_o, pg_vld_o, pg_commit_o, sr_wr_o}, 0);
        rst_n = 1'b1;
        #(4*H);

        // R1 R9: enable, with and without bit 3, both modes (R12).
        exp_q.push_back({8'd1, 16'd0, 8'd0}); one_cmd(8'h06, 1'b0); sb_drain("R9 enable");
        exp_q.push_back({8'd1, 16'd0, 8'd0}); one_cmd(8'h0E, 1'b1); sb_drain("R1 R12 bit3 ignored");
        exp_q.push_back({8'd2, 16'd0, 8'd0}); one_cmd(8'h04, 1'b0); sb_drain("R9 disable");

        // R8: status streamed and reloaded per byte.
        status = 8'hA5; do_rdsr(2, 8'hA5, 1'b0, "R8 status");
        status = 8'h3C; do_rdsr(1, 8'h3C, 1'b1, "R8 R12 status");

        // R2 R6: reads, wrap, ignored high bit, mode 3 (R12).
        do_read(8'h03, 16'h0100, 3, 1'b0, -1, -1, "R2 R6 read");
        do_read(8'h0B, 16'h7FFE, 4, 1'b1, -1, -1, "R6 R12 wrap");
        do_read(8'h03, 16'h8010, 2, 1'b0, -1, -1, "R6 high bit ignored");

        // R5: pause inside an address byte and inside a data byte.
        do_read(8'h03, 16'h2345, 2, 1'b0, 3, 4, "R5 pause keeps sequence");
        do_read(8'h03, 16'h0456, 1, 1'b1, -1, 2, "R5 R12 pause");

        // R3: invalid commands lock out until select falls again.
        oe_seen = 1'b0;
        begin_x(1'b0); xbyte(8'h83, -1, rx); xbyte(8'h06, -1, rx); xbyte(8'h03, -1, rx); end_x(1'b0);
        chk(!oe_seen, "R3 no output after invalid", oe_seen, 0);
        oe_seen = 1'b0;
        begin_x(1'b1); xbyte(8'h07, -1, rx); xbyte(8'h05, -1, rx); end_x(1'b1);
        chk(!oe_seen, "R1 R3 code 111 invalid", oe_seen, 0);
        sb_drain("R3 no request after invalid");
        do_read(8'h03, 16'h0042, 1, 1'b0, -1, -1, "R3 R2 next transaction decoded");

        // R4: clocks and data while deselected do nothing.
        oe_seen = 1'b0;
        sck = 1'b0;
        for (int k = 0; k < 24; k++) begin
            si = (k % 3 == 0); sck = ~sck; #H;
        end
        sck = 1'b0; #H;
        chk(!oe_seen, "R4 deselected clocks ignored", oe_seen, 0);
        sb_drain("R4 no request while deselected");

        // R7: busy ignores all but status read.
        busy = 1'b1;
        one_cmd(8'h06, 1'b0); sb_drain("R7 enable ignored while busy");
        oe_seen = 1'b0;
        begin_x(1'b0); xbyte(8'h03, -1, rx); xbyte(8'h00, -1, rx); xbyte(8'h10, -1, rx);
        xbyte(8'h00, -1, rx); end_x(1'b0);
        chk(!oe_seen, "R7 read ignored while busy", oe_seen, 0);
        status = 8'hFF; do_rdsr(1, 8'hFF, 1'b0, "R7 R8 status while busy");
        busy = 1'b0;

        // R10: write refused without grant.
        grant = 1'b0;
        begin_x(1'b0); xbyte(8'h02, -1, rx); xbyte(8'h00, -1, rx); xbyte(8'h20, -1, rx);
        xbyte(8'h55, -1, rx); end_x(1'b0);
        sb_drain("R10 write refused without grant");

        // R10: page write with wrap inside the page and commit.
        grant = 1'b1;
        exp_q.push_back({8'd3, 16'h127E, 8'h11});
        exp_q.push_back({8'd3, 16'h127F, 8'h22});
        exp_q.push_back({8'd3, 16'h1200, 8'h33});
        exp_q.push_back({8'd4, 16'd0, 8'd0});
        begin_x(1'b0); xbyte(8'h0A, -1, rx); xbyte(8'h12, -1, rx); xbyte(8'h7E, -1, rx);
        xbyte(8'h11, -1, rx); xbyte(8'h22, -1, rx); xbyte(8'h33, -1, rx); end_x(1'b0);
        sb_drain("R10 page write and commit");

        // R10: select rising mid-byte gives no commit.
        exp_q.push_back({8'd3, 16'h0300, 8'h9C});
        begin_x(1'b1); xbyte(8'h02, -1, rx); xbyte(8'h03, -1, rx); xbyte(8'h00, -1, rx);
        xbyte(8'h9C, -1, rx);
        for (int i = 0; i < 3; i++) begin sck = 1'b0; si = 1'b1; #H; sck = 1'b1; #H; end
        end_x(1'b1);
        sb_drain("R10 no commit off byte boundary");

        // R11: status write with and without grant.
        exp_q.push_back({8'd5, 16'd0, 8'h8C});
        begin_x(1'b0); xbyte(8'h01, -1, rx); xbyte(8'h8C, -1, rx); end_x(1'b0);
        sb_drain("R11 status write");
        grant = 1'b0;
        begin_x(1'b0); xbyte(8'h01, -1, rx); xbyte(8'h0C, -1, rx); end_x(1'b0);
        sb_drain("R11 status write refused");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule